// File: doc/BRIEF.md
# Multithread Fetch Issue Scheduler

In a multithreaded core, several hardware threads share one fetch unpacking stage. This block decides, once per cycle, which thread that stage serves. A thread takes part only when three things are true: it is active, a fetched line is waiting for it, and the buffer in front of the next stage still has room to reserve for it. The grant is combinational from the current inputs and two registers. One register is a priority reference that holds the last granted thread. The other is a 16-bit LFSR used by the random policy.

A two-bit policy input selects how candidates are ordered. Fixed mode serves thread 0 only. Round-robin mode searches circularly from the thread after the last one granted. Random mode searches circularly from a start thread taken from the LFSR. A separate busy output tells the activity logic whether any thread has both waiting input and space downstream.

Top module: `fetch_thread_sched`

## Requirements
- R1: A thread is eligible only when its `thr_active`, `line_ready` and `slot_free` bits are all 1. `grant_valid` is 1 only for an eligible `grant_tid`. When no candidate qualifies under the active policy, `grant_valid` is 0.
- R2: With `policy` = 2'b00 (fixed), only thread 0 can be granted. If thread 0 is not eligible, nothing is granted, even when other threads are eligible.
- R3: With `policy` = 2'b01 (round-robin), the grant goes to the first eligible thread found by searching from (reference + 1) mod NTHREADS upward, wrapping modulo NTHREADS.
- R4: Every valid grant loads the granted ID into the priority reference at the next clock edge. A cycle without a grant leaves the reference unchanged. This applies under every policy.
- R5: With `policy` = 2'b10 (random), the search starts at (LFSR value mod NTHREADS) and proceeds circularly like R3.
- R6: The LFSR is a left-shifting 16-bit register. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. It advances on every clock edge outside reset, whether or not a grant occurs.
- R7: Reset is synchronous and active high. It sets the reference to thread 0 and the LFSR to 16'hACE1. While `rst` is 1, `grant_valid` is 0.
- R8: `stage_busy` is 1 exactly when some thread has both `line_ready` and `slot_free` set, whatever its `thr_active` bit.
- R9: `policy` = 2'b11 is reserved and grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy | input | 2 | 00 fixed, 01 round-robin, 10 random, 11 reserved |
| thr_active | input | NTHREADS | Per-thread active state |
| line_ready | input | NTHREADS | Per-thread fetched line waiting |
| slot_free | input | NTHREADS | Per-thread downstream reservation possible |
| grant_valid | output | 1 | A thread is served this cycle |
| grant_tid | output | TID_W | Served thread ID, meaningful with grant_valid |
| stage_busy | output | 1 | Some thread has input and downstream space |

## Verification
The assertions check on every cycle that:
- a grant always names a fully eligible thread;
- fixed mode never serves a thread other than 0;
- the reserved code and an asserted reset never grant;
- a grant implies the busy output;
- the LFSR never reaches zero;
- in round-robin mode the thread right after the reference wins whenever it is eligible.

Only the bench's scenarios can show the rest:
- the full circular search order with holes in the eligibility pattern;
- that cycles without a grant leave the reference alone;
- that the random start follows the LFSR sequence cycle by cycle;
- that a reset in mid-run restores round-robin order from thread 1.

// File: rtl/fetch_thread_sched.sv
module fetch_thread_sched #(
  parameter int NTHREADS = 4,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          policy,
  input  logic [NTHREADS-1:0] thr_active,
  input  logic [NTHREADS-1:0] line_ready,
  input  logic [NTHREADS-1:0] slot_free,
  output logic                grant_valid,
  output logic [TID_W-1:0]    grant_tid,
  output logic                stage_busy
);
  localparam logic [NTHREADS-1:0] THREAD0 = NTHREADS'(1);

  logic [NTHREADS-1:0] elig, cand;
  logic [TID_W-1:0]    last_q;
  logic [15:0]         lfsr_q;
  logic                fb;
  int                  start_i;

  assign elig       = thr_active & line_ready & slot_free;
  assign stage_busy = |(line_ready & slot_free);
  assign fb         = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_comb begin
    cand    = elig;
    start_i = 0;
    case (policy)
      2'b00:   cand = elig & THREAD0;
      2'b01:   start_i = (int'(last_q) + 1) % NTHREADS;
      2'b10:   start_i = int'(lfsr_q % 16'(NTHREADS));
      default: cand = '0;
    endcase
    if (rst) cand = '0;
    grant_valid = 1'b0;
    grant_tid   = '0;
    for (int k = 0; k < NTHREADS; k++) begin
      if (!grant_valid && cand[(start_i + k) % NTHREADS]) begin
        grant_valid = 1'b1;
        grant_tid   = TID_W'((start_i + k) % NTHREADS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      lfsr_q <= SEED;
    end else begin
      lfsr_q <= {lfsr_q[14:0], fb};
      if (grant_valid) last_q <= grant_tid;
    end
  end

  logic [TID_W-1:0] rr_after;
  assign rr_after = TID_W'((int'(last_q) + 1) % NTHREADS);

  p_grant_elig_r1: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (thr_active[grant_tid] && line_ready[grant_tid] && slot_free[grant_tid]));
  p_fixed_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && policy == 2'b00) |-> grant_tid == '0);
  p_rr_next_r3: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'b01 && elig[rr_after]) |-> (grant_valid && grant_tid == rr_after));
  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (rst) lfsr_q != 16'h0);
  p_reset_quiet_r7: assert property (@(posedge clk) rst |-> !grant_valid);
  p_grant_busy_r8: assert property (@(posedge clk) disable iff (rst) grant_valid |-> stage_busy);
  p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'b11) |-> !grant_valid);
endmodule

// File: tb/test_fetch_thread_sched.sv
module test_fetch_thread_sched;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] policy = 2'b01;
  logic [N-1:0] thr_active = '0, line_ready = '0, slot_free = '0;
  logic grant_valid, stage_busy;
  logic [1:0] grant_tid;

  fetch_thread_sched i_fetch_thread_sched (
    .clk(clk), .rst(rst), .policy(policy), .thr_active(thr_active),
    .line_ready(line_ready), .slot_free(slot_free), .grant_valid(grant_valid),
    .grant_tid(grant_tid), .stage_busy(stage_busy));

  always #4 clk = ~clk;

  typedef struct { bit v; bit [1:0] t; bit b; string tag; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0]  m_last;
  logic [15:0] m_lfsr;
  bit          m_pv;
  logic [1:0]  m_pt;

  function automatic logic [15:0] lstep(logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  task automatic chk(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", tag, msg); end
  endtask

  task automatic drive(logic [1:0] pol, logic [N-1:0] act, logic [N-1:0] rdy,
                       logic [N-1:0] fre, string tag);
    item_t it;
    logic [N-1:0] e;
    int st;
    @(posedge clk); #1;
    if (m_pv) m_last = m_pt;
    m_lfsr = lstep(m_lfsr);
    policy = pol; thr_active = act; line_ready = rdy; slot_free = fre;
    e = act & rdy & fre;
    it.v = 0; it.t = 0; it.b = |(rdy & fre); it.tag = tag;
    st = 0;
    if (pol == 2'b00) e = e & 4'b0001;
    else if (pol == 2'b01) st = (int'(m_last) + 1) % N;
    else if (pol == 2'b10) st = int'(m_lfsr[1:0]);
    else e = '0;
    for (int k = 0; k < N; k++)
      if (!it.v && e[(st + k) % N]) begin it.v = 1; it.t = 2'((st + k) % N); end
    m_pv = it.v; m_pt = it.t;
    sb.push_back(it);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1; policy = 2'b01; thr_active = '1; line_ready = '1; slot_free = '1;
    @(posedge clk); @(negedge clk);
    chk(grant_valid == 0, "R7", $sformatf("grant_valid=%0b exp 0 in reset", grant_valid));
    @(posedge clk); #1;
    rst = 0; thr_active = '0; line_ready = '0; slot_free = '0;
    m_last = 0; m_lfsr = 16'hACE1; m_pv = 0;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(grant_valid == it.v && (!it.v || grant_tid == it.t) && stage_busy == it.b, it.tag,
          $sformatf("valid=%0b tid=%0d busy=%0b exp valid=%0b tid=%0d busy=%0b",
                    grant_valid, grant_tid, stage_busy, it.v, it.t, it.b));
    end
  end

  initial begin
    do_reset();
    drive(2'b01, '1, '1, '1, "R7 rr first after reset");
    for (int i = 0; i < 5; i++) drive(2'b01, '1, '1, '1, "R3 rr all eligible");
    drive(2'b01, 4'b1001, '1, '1, "R3 rr holes");
    drive(2'b01, 4'b1001, '1, '1, "R3 rr wrap");
    drive(2'b01, '1, 4'b0000, '1, "R4 no grant");
    drive(2'b01, '1, '1, '1, "R4 ref kept");
    drive(2'b01, 4'b1011, 4'b1101, 4'b0111, "R1 partial eligibility");
    drive(2'b01, 4'b0100, 4'b0100, 4'b0000, "R1 blocked downstream");
    drive(2'b00, '1, 4'b1110, '1, "R2 fixed thread0 idle");
    drive(2'b00, '1, '1, '1, "R2 fixed grants 0");
    drive(2'b01, '1, '1, '1, "R4 ref from fixed grant");
    drive(2'b11, '1, '1, '1, "R9 reserved");
    for (int i = 0; i < 8; i++) drive(2'b10, '1, '1, '1, "R5 random all");
    for (int i = 0; i < 3; i++) drive(2'b10, '0, '0, '0, "R6 idle lfsr steps");
    for (int i = 0; i < 6; i++) drive(2'b10, 4'b0110, '1, '1, "R5 random masked");
    drive(2'b01, 4'b0000, 4'b1000, 4'b1000, "R8 busy though inactive");
    drive(2'b01, '1, 4'b0011, 4'b1100, "R8 not busy");
    do_reset();
    drive(2'b01, '1, '1, '1, "R7 rr after mid reset");
    drive(2'b10, '1, '1, '1, "R6 lfsr reseeded");
    @(posedge clk); @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: timeout, exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule